// File: doc/BRIEF.md
# Asynchronous SRAM Controller

This block lets a clocked host read and write an external asynchronous static RAM of 8K bytes. The host raises a request with an address, a write flag and write data, and holds it until the controller answers with a one-cycle ready pulse. For a read, the byte fetched from the memory is on the read-data port during that pulse.

On the memory side the controller drives the address bus, a pair of chip enables of opposite polarity, a write strobe and an output-enable strobe. It also drives a split data bus: data out, data in and a driver enable. Every minimum time the memory needs is met by holding a phase for a whole number of clock cycles. Each count is the ceiling of the nanosecond minimum divided by the clock-period parameter, and is never less than one. Writes are controlled by the write strobe, with output enable held high. Before the controller drives the data bus it waits out the memory's output release time.

Top module: `asram_host_bridge`

## Requirements
- R1: After reset both chip enables are inactive (active-low enable high, active-high enable low), both strobes are high, the data driver is off and ready is low.
- R2: The memory is selected (active-low enable low and active-high enable high) from the cycle after a request is accepted until the access ends. In every other cycle both enables are inactive.
- R3: A read keeps output enable low and the write strobe high for ceil(70 ns / period) cycles, 7 at 10 ns. The read data returned equals the memory data present in the last of those cycles.
- R4: During a write, output enable stays high for the whole access.
- R5: A write holds the memory selected with the write strobe high and the driver off for ceil(35 ns / period) cycles, 4 at 10 ns. The data driver is never on while output enable is low.
- R6: The write strobe stays low for max(ceil(50 ns/period), ceil(40 ns/period), ceil(70 ns/period) minus the setup count) cycles, 5 at 10 ns. Throughout, the driver is on and carries the latched write data.
- R7: A write ends with the strobe rising while both enables stay active. The enables and the driver then stay on for max(1, ceil(70 ns/period) minus setup minus strobe) cycles, 1 at 10 ns, and drop together in the following cycle.
- R8: Ready is a one-cycle pulse, asserted in the cycle after the read wait or in the last write-recovery cycle. A request is taken only when idle, so toggling the request during an access starts nothing else.
- R9: Address and write data are latched when the request is accepted. Host input changes during an access do not alter the memory address or data bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_req | input | 1 | Access request, held until ready |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 13 | Word address |
| host_wdata | input | 8 | Write data |
| host_ready | output | 1 | One-cycle completion pulse |
| host_rdata | output | 8 | Read data, valid with ready after a read |
| mem_addr | output | 13 | Memory address bus |
| mem_cs_n | output | 1 | Active-low chip enable |
| mem_cs | output | 1 | Active-high chip enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_in | input | 8 | Data returned by the memory |
| mem_dq_oe | output | 1 | Driver enable for the data bus |

## Verification
The bench's memory model returns inverted garbage until the read has been held for the full access count. A controller that sampled one cycle early would therefore return wrong bytes. Every access is traced pin by pin, and each phase length is compared with counts computed from the period. This catches a write strobe that is too short, a driver that turns on during the setup phase, or a write that ends by dropping the enables. The host inputs are scrambled and the request is toggled mid-access, so a controller that failed to latch its inputs, or that re-accepted a request while busy, would show a wrong address or an extra access.

// File: rtl/asram_pkg.sv
// Shared types and cycle-count helpers for the asynchronous SRAM controller.
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_WAIT,
        ST_RD_DONE,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_REC
    } asram_state_t;

    // Cycles covering ns at the given period, never below one.
    function automatic int unsigned cyc_of(input int unsigned ns, input int unsigned per);
        int unsigned c;
        c = (ns + per - 1) / per;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_tick_ctr.sv
// Down counter that times each controller phase.
// Assumes: loaded with (length-1) on phase entry; zero flags the last cycle.
module asram_tick_ctr #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [CNT_W-1:0] ld_val,
    output logic             zero
);
    logic [CNT_W-1:0] cnt;

    // Load on phase entry, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (ld)
            cnt <= ld_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/asram_seq.sv
// Access sequencer: read wait, read done, write setup, strobe and recovery.
// Assumes: the phase counter flags the last cycle of each timed phase.
module asram_seq
    import asram_pkg::*;
#(
    parameter int CNT_W  = 4,
    parameter int RD_CYC = 7,
    parameter int SU_CYC = 4,
    parameter int PW_CYC = 5,
    parameter int RC_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             wr,
    input  logic             cnt_zero,
    output asram_state_t     nxt,
    output logic             ld,
    output logic [CNT_W-1:0] ld_val,
    output logic             accept,
    output logic             capture,
    output logic             ready
);
    localparam logic [CNT_W-1:0] RD_LD = CNT_W'(RD_CYC - 1);
    localparam logic [CNT_W-1:0] SU_LD = CNT_W'(SU_CYC - 1);
    localparam logic [CNT_W-1:0] PW_LD = CNT_W'(PW_CYC - 1);
    localparam logic [CNT_W-1:0] RC_LD = CNT_W'(RC_CYC - 1);

    asram_state_t state;

    // Next phase from current phase, request and counter.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:     if (req) nxt = wr ? ST_WR_SETUP : ST_RD_WAIT;
            ST_RD_WAIT:  if (cnt_zero) nxt = ST_RD_DONE;
            ST_RD_DONE:  nxt = ST_IDLE;
            ST_WR_SETUP: if (cnt_zero) nxt = ST_WR_PULSE;
            ST_WR_PULSE: if (cnt_zero) nxt = ST_WR_REC;
            ST_WR_REC:   if (cnt_zero) nxt = ST_IDLE;
            default:     nxt = ST_IDLE;
        endcase
    end

    // Counter preset for the phase being entered.
    always_comb begin
        unique case (nxt)
            ST_RD_WAIT:  ld_val = RD_LD;
            ST_WR_SETUP: ld_val = SU_LD;
            ST_WR_PULSE: ld_val = PW_LD;
            ST_WR_REC:   ld_val = RC_LD;
            default:     ld_val = '0;
        endcase
    end

    assign ld      = (nxt != state);
    assign accept  = (state == ST_IDLE) && req;
    assign capture = (state == ST_RD_WAIT) && cnt_zero;
    assign ready   = (state == ST_RD_DONE) || ((state == ST_WR_REC) && cnt_zero);

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nxt;
    end
endmodule

// File: rtl/asram_pin_drv.sv
// Registered memory pins and host data latches.
// Assumes: pins are decoded from the next phase so they change with the phase.
module asram_pin_drv
    import asram_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  asram_state_t      nxt,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe
);
    logic sel_nxt;
    assign sel_nxt = (nxt == ST_RD_WAIT) || (nxt == ST_WR_SETUP) ||
                     (nxt == ST_WR_PULSE) || (nxt == ST_WR_REC);

    // Strobe and enable registers, glitch-free at the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_cs_n  <= 1'b1;
            mem_cs    <= 1'b0;
            mem_we_n  <= 1'b1;
            mem_oe_n  <= 1'b1;
            mem_dq_oe <= 1'b0;
        end else begin
            mem_cs_n  <= !sel_nxt;
            mem_cs    <= sel_nxt;
            mem_we_n  <= (nxt != ST_WR_PULSE);
            mem_oe_n  <= (nxt != ST_RD_WAIT);
            mem_dq_oe <= (nxt == ST_WR_PULSE) || (nxt == ST_WR_REC);
        end
    end

    // Latch address and write data when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (accept) begin
            mem_addr   <= host_addr;
            mem_dq_out <= host_wdata;
        end
    end

    // Capture read data on the last wait cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            host_rdata <= '0;
        else if (capture)
            host_rdata <= mem_dq_in;
    end
endmodule

// File: rtl/asram_host_bridge.sv
// Top: synchronous host port to an asynchronous 8-bit SRAM.
// Assumes: host holds req until ready; all timings are met by cycle counts
// derived from CLK_NS and the nanosecond minimums below.
module asram_host_bridge
    import asram_pkg::*;
#(
    parameter int CLK_NS    = 10,
    parameter int ADDR_W    = 13,
    parameter int DATA_W    = 8,
    parameter int T_RC_NS   = 70,
    parameter int T_WP_NS   = 50,
    parameter int T_WC_NS   = 70,
    parameter int T_AW_NS   = 70,
    parameter int T_DW_NS   = 40,
    parameter int T_OHZ_NS  = 30,
    parameter int T_WHZ_NS  = 35
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cs_n,
    output logic              mem_cs,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int RD_CYC = int'(cyc_of(T_RC_NS, CLK_NS));
    localparam int SU_CYC = int'(cyc_of(max2(T_OHZ_NS, T_WHZ_NS), CLK_NS));
    localparam int AW_CYC = int'(cyc_of(T_AW_NS, CLK_NS));
    localparam int WC_CYC = int'(cyc_of(T_WC_NS, CLK_NS));
    localparam int PW_CYC = int'(max2(max2(cyc_of(T_WP_NS, CLK_NS), cyc_of(T_DW_NS, CLK_NS)),
                                      (AW_CYC > SU_CYC) ? AW_CYC - SU_CYC : 1));
    localparam int RC_CYC = (WC_CYC > SU_CYC + PW_CYC) ? WC_CYC - SU_CYC - PW_CYC : 1;
    localparam int MAX_CYC = int'(max2(max2(RD_CYC, SU_CYC), max2(PW_CYC, RC_CYC)));
    localparam int CNT_W  = $clog2(MAX_CYC + 1);

    asram_state_t     nxt;
    logic             ld, accept, capture, cnt_zero;
    logic [CNT_W-1:0] ld_val;

    asram_seq #(
        .CNT_W (CNT_W), .RD_CYC(RD_CYC), .SU_CYC(SU_CYC),
        .PW_CYC(PW_CYC), .RC_CYC(RC_CYC)
    ) seq_i (
        .clk(clk), .rst_n(rst_n), .req(host_req), .wr(host_wr),
        .cnt_zero(cnt_zero), .nxt(nxt), .ld(ld), .ld_val(ld_val),
        .accept(accept), .capture(capture), .ready(host_ready)
    );

    asram_tick_ctr #(.CNT_W(CNT_W)) ctr_i (
        .clk(clk), .rst_n(rst_n), .ld(ld), .ld_val(ld_val), .zero(cnt_zero)
    );

    asram_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) pins_i (
        .clk(clk), .rst_n(rst_n), .nxt(nxt), .accept(accept), .capture(capture),
        .host_addr(host_addr), .host_wdata(host_wdata), .mem_dq_in(mem_dq_in),
        .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe)
    );
endmodule

// File: rtl/asram_host_bridge_chk.sv
// Protocol checker for the SRAM controller pins, bound to the top module.
module asram_host_bridge_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cs_n,
    input logic              mem_cs,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);
    logic sel;
    assign sel = !mem_cs_n && mem_cs;

    assert_no_drive_on_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe && !mem_oe_n));
    assert_oe_high_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);
    assert_read_strobe_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_oe_n |-> (sel && mem_we_n));
    assert_strobe_drives_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_dq_oe);
    assert_write_ends_selected_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_n && !$past(mem_we_n)) |-> sel);
    assert_driver_selected_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> sel);
    assert_ready_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |=> !host_ready);
    assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && $past(sel)) |-> $stable(mem_addr));
endmodule

bind asram_host_bridge asram_host_bridge_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .host_ready(host_ready), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n),
    .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/asram_host_bridge_tb_top.sv
// Bench: behavioural SRAM model plus a pin-tracing host driver.
module asram_host_bridge_tb_top;
    localparam int PER = 10;
    localparam int E_RD = (70 + PER - 1) / PER;
    localparam int E_SU = (35 + PER - 1) / PER;
    localparam int E_PW_A = (50 + PER - 1) / PER;
    localparam int E_PW_B = ((70 + PER - 1) / PER) - E_SU;
    localparam int E_PW = (E_PW_A > E_PW_B) ? E_PW_A : E_PW_B;
    localparam int E_RC_R = ((70 + PER - 1) / PER) - E_SU - E_PW;
    localparam int E_RC = (E_RC_R > 1) ? E_RC_R : 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0, host_wr = 1'b0;
    logic [12:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_ready;
    logic [7:0]  host_rdata;
    logic [12:0] mem_addr;
    logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [7:0]  mem_dq_out, mem_dq_in;

    int n_chk = 0, n_fail = 0;
    logic [7:0] mem_m [256];
    int rd_age = 0;

    always #5ns clk = ~clk;

    asram_host_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_ready(host_ready),
        .host_rdata(host_rdata), .mem_addr(mem_addr), .mem_cs_n(mem_cs_n),
        .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    // Memory model: data valid only once a read has been held long enough.
    wire m_sel = !mem_cs_n && mem_cs;
    wire m_rd  = m_sel && !mem_oe_n && mem_we_n;
    assign mem_dq_in = !m_rd ? 8'h00 :
                       (rd_age >= E_RD - 1) ? mem_m[mem_addr[7:0]] : ~mem_m[mem_addr[7:0]];

    always @(posedge clk) begin
        rd_age <= m_rd ? rd_age + 1 : 0;
        if (m_sel && !mem_we_n && mem_dq_oe) mem_m[mem_addr[7:0]] <= mem_dq_out;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic access(input bit w, input logic [12:0] a, input logic [7:0] d,
                          input logic [7:0] exp_rd);
        int n_cyc = 0, n_sel = 0, n_oe = 0, n_we = 0, n_su = 0, n_drv = 0;
        bit seen_we = 0, addr_bad = 0, data_bad = 0, oe_in_wr = 0, early = 0, done = 0;
        bit last_sel = 0, last_we = 0, last_drv = 0;
        logic [7:0] rd = '0;
        @(negedge clk);
        host_req = 1; host_wr = w; host_addr = a; host_wdata = d;
        while (!done) begin
            @(negedge clk);
            n_cyc++;
            if (n_cyc == 1) begin host_addr = ~a; host_wdata = ~d; host_wr = !w; end
            if (n_cyc == 2) host_req = 0;
            if (n_cyc == 3) host_req = 1;
            if (m_sel) n_sel++;
            if (m_sel && mem_addr != a) addr_bad = 1;
            if (!mem_oe_n) n_oe++;
            if (w && !mem_oe_n) oe_in_wr = 1;
            if (!mem_we_n) begin
                n_we++; seen_we = 1;
                if (mem_dq_out != d) data_bad = 1;
            end
            if (w && m_sel && mem_we_n && !seen_we) begin
                n_su++;
                if (mem_dq_oe) early = 1;
            end
            if (mem_dq_oe) n_drv++;
            if (host_ready) begin
                done = 1; rd = host_rdata;
                last_sel = m_sel; last_we = mem_we_n; last_drv = mem_dq_oe;
            end
            if (n_cyc > 60) begin
                chk(0, "watchdog", n_cyc, 0);
                done = 1;
            end
        end
        host_req = 0;
        chk(!addr_bad, "R9 address latched", int'(mem_addr), int'(a));
        if (w) begin
            chk(n_cyc == E_SU + E_PW + E_RC, "R8 write ready cycle", n_cyc, E_SU + E_PW + E_RC);
            chk(n_sel == E_SU + E_PW + E_RC, "R2 write select span", n_sel, E_SU + E_PW + E_RC);
            chk(!oe_in_wr, "R4 oe high in write", int'(oe_in_wr), 0);
            chk(n_su == E_SU && !early, "R5 turnaround setup", n_su, E_SU);
            chk(n_we == E_PW, "R6 strobe width", n_we, E_PW);
            chk(!data_bad, "R6 R9 write data", int'(data_bad), 0);
            chk(last_sel && last_we && n_drv == E_PW + E_RC, "R7 recovery", n_drv, E_PW + E_RC);
        end else begin
            chk(n_cyc == E_RD + 1, "R8 read ready cycle", n_cyc, E_RD + 1);
            chk(n_sel == E_RD && !last_sel, "R2 read select span", n_sel, E_RD);
            chk(n_oe == E_RD && n_we == 0 && n_drv == 0, "R3 read strobes", n_oe, E_RD);
            chk(rd == exp_rd, "R3 read data", int'(rd), int'(exp_rd));
        end
        @(negedge clk);
        chk(!m_sel && !mem_dq_oe && !host_ready, "R7 R8 release after ready",
            int'({m_sel, mem_dq_oe, host_ready}), 0);
        @(negedge clk);
        chk(!m_sel && !host_ready, "R8 no extra access", int'({m_sel, host_ready}), 0);
        if (last_drv && !w) chk(0, "R5 driver in read", 1, 0);
    endtask

    function automatic logic [12:0] adr_of(input int i);
        return 13'((i * 129) & 13'h1FFF);
    endfunction

    function automatic logic [7:0] dat_of(input int i);
        case (i)
            0: return 8'h00;
            1: return 8'hFF;
            2: return 8'hAA;
            3: return 8'h55;
            default: return 8'((i * 37 + 11) & 8'hFF);
        endcase
    endfunction

    initial begin
        for (int k = 0; k < 256; k++) mem_m[k] = 8'h00;
        repeat (3) @(negedge clk);
        chk(mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe && !host_ready,
            "R1 reset pins", int'({mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_dq_oe, host_ready}),
            6'b101100);
        rst_n = 1;
        @(negedge clk);
        chk(mem_cs_n && !mem_cs && !host_ready, "R1 idle after reset",
            int'({mem_cs_n, mem_cs, host_ready}), 3'b100);
        for (int i = 0; i < 64; i++) access(1, adr_of(i), dat_of(i), 8'h00);
        for (int i = 0; i < 64; i++) access(0, adr_of(i), 8'h00, dat_of(i));
        access(1, 13'h1FFF, 8'hC5, 8'h00);
        access(0, 13'h1FFF, 8'h00, 8'hC5);
        access(1, 13'h0000, 8'h3C, 8'h00);
        access(1, 13'h0000, 8'h96, 8'h00);
        access(0, 13'h0000, 8'h00, 8'h96);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog expired", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule